// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller sits between a synchronous host and a 2048 x 8 asynchronous static RAM. The RAM has active-low chip, write and output enables and one shared 8-bit data bus. The host asks for a read or a write with a request/ready handshake. The controller then produces the enable sequence for the memory, holds the address steady for the whole access, drives write data through a tri-state enable and captures read data. A read ends with a one-cycle valid pulse.

Every memory minimum is a parameter in nanoseconds, and a clock-period parameter converts it to a whole number of cycles. The conversion rounds up and never gives less than one cycle. This covers the access times, the write pulse, chip-enable-to-end-of-write, data setup, cycle time and the time the memory may keep driving the bus after a read.

Between requests the controller deselects the memory, which then falls to standby. A write that follows a read waits until the memory has released the bus.

Top module: `sram_access_ctrl`

## Requirements
- R1: While rst_ni is low, mem_ce_n_o, mem_we_n_o and mem_oe_n_o are 1, mem_dq_oe_o is 0, ready_o is 1 and rvalid_o is 0.
- R2: In any cycle where ready_o is 1, the memory is in standby: mem_ce_n_o, mem_we_n_o and mem_oe_n_o are all 1, and mem_dq_oe_o is 0.
- R3: An accepted write (we_i=1) drives mem_ce_n_o=0, mem_we_n_o=0 and mem_oe_n_o=1, with mem_dq_oe_o=1 and wdata_i on mem_dq_o. The write pulse meets the write pulse width, chip-enable-to-end-of-write, data setup and write cycle minimums. The byte is stored at addr_i.
- R4: An accepted read (we_i=0) drives mem_ce_n_o=0, mem_we_n_o=1 and mem_oe_n_o=0 with the bus released. It returns the last byte written to that address on rdata_o, with rvalid_o high for exactly one cycle.
- R5: mem_oe_n_o and mem_we_n_o are never both 0.
- R6: mem_dq_oe_o is 1 only while mem_oe_n_o is 1. It rises no earlier than ceil(T_HZ_NS/CLK_NS) cycles after the end of a read, so the memory and the controller never drive the bus at the same time.
- R7: Each minimum becomes max(1, ceil(t/CLK_NS)) cycles. rvalid_o rises exactly ceil(max(T_RC,T_AA,T_OE)/CLK) cycles after the accepting edge. mem_we_n_o stays low for exactly ceil(max(T_WC,T_WP,T_CW,T_DS)/CLK) cycles.
- R8: mem_addr_o does not change while mem_ce_n_o stays 0.
- R9: A request is accepted at a clock edge where req_i and ready_o are both 1. ready_o is 0 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| ready_o | output | 1 | Controller can accept a request |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | One-cycle read data valid |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven onto the memory bus |
| mem_dq_oe_o | output | 1 | Tri-state enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data seen on the memory bus |

## Verification
The hardest situation to reach from the ports is a write that starts on the earliest cycle the controller allows after a read, because that is the only point where bus turnaround can fail. The stimulus polls ready_o on every cycle and issues a write the moment it rises after a read. The memory model keeps driving the bus for the full release time and flags any overlap with mem_dq_oe_o. The model returns corrupted data until both access times have elapsed, so a read sampled even one cycle early shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_HOLD
  } seq_state_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // round up, never below one cycle
  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= sample_i;
      if (sample_i) rdata_o <= dq_i;
    end
  end

  p_rvalid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int N_RD  = 9,
  parameter int N_WR  = 9,
  parameter int N_HZ  = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             ready_o,
  output logic             start_o,
  output logic             sample_o,
  output logic             ce_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);

  seq_state_e state_q, state_d;

  // the last turnaround cycle may already accept the next request
  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_TURN && tmr_done_i);
  assign start_o = req_i && ready_o;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sample_o   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_TURN: begin
        if (start_o) begin
          tmr_load_o = 1'b1;
          if (we_i) begin
            state_d   = ST_WR;
            tmr_val_o = CNT_W'(N_WR - 1);
          end else begin
            state_d   = ST_RD;
            tmr_val_o = CNT_W'(N_RD - 1);
          end
        end else if (state_q == ST_TURN && tmr_done_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_RD: if (tmr_done_i) begin
        sample_o   = 1'b1;
        state_d    = ST_TURN;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(N_HZ - 1);
      end
      ST_WR: if (tmr_done_i) state_d = ST_HOLD;
      ST_HOLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // memory strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_o  <= !(state_d == ST_RD || state_d == ST_WR);
      we_n_o  <= !(state_d == ST_WR);
      oe_n_o  <= !(state_d == ST_RD);
      dq_oe_o <= (state_d == ST_WR) || (state_d == ST_HOLD);
    end
  end

  p_oe_we_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !oe_n_o));

  p_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ce_n_o && we_n_o && oe_n_o && !dq_oe_o));

  p_busy_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !ready_o);

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 8,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 40,
  parameter int T_CW_NS = 45,
  parameter int T_DS_NS = 30,
  parameter int T_HZ_NS = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              mem_ce_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_RD  = ns2cyc(max_i(T_RC_NS, max_i(T_AA_NS, T_OE_NS)), CLK_NS);
  localparam int N_WR  = ns2cyc(max_i(max_i(T_WC_NS, T_WP_NS), max_i(T_CW_NS, T_DS_NS)), CLK_NS);
  localparam int N_HZ  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int CNT_W = $clog2(max_i(N_RD, max_i(N_WR, N_HZ)) + 1);

  logic             tmr_load, tmr_done, start, sample;
  logic [CNT_W-1:0] tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  sram_ctrl_seq #(
    .N_RD(N_RD), .N_WR(N_WR), .N_HZ(N_HZ), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .ready_o    (ready_o),
    .start_o    (start),
    .sample_o   (sample),
    .ce_n_o     (mem_ce_n_o),
    .we_n_o     (mem_we_n_o),
    .oe_n_o     (mem_oe_n_o),
    .dq_oe_o    (mem_dq_oe_o)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .dq_i     (mem_dq_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // pin-level window counters for the timing properties
  logic [CNT_W-1:0] oe_hi_q, we_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_hi_q <= CNT_W'(N_HZ);
      we_lo_q <= '0;
    end else begin
      if (!mem_oe_n_o)                  oe_hi_q <= '0;
      else if (oe_hi_q != CNT_W'(N_HZ)) oe_hi_q <= oe_hi_q + 1'b1;
      if (mem_we_n_o)                   we_lo_q <= '0;
      else if (we_lo_q != CNT_W'(N_WR)) we_lo_q <= we_lo_q + 1'b1;
    end
  end

  p_drive_oe_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (oe_hi_q >= CNT_W'(N_HZ)));

  p_we_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_q >= CNT_W'(N_WR)));

  p_addr_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

endmodule

// File: tb/tb_sram_access_ctrl.sv
`timescale 1ns/1ps
module tb_sram_access_ctrl;

  localparam int CLK  = 8;
  localparam int T_RC = 70, T_AA = 70, T_OE = 35, T_WC = 70;
  localparam int T_WP = 40, T_CW = 45, T_DS = 30, T_HZ = 30;

  function automatic int cyc_of(input int t);
    int c;
    c = (t + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_RD = cyc_of(mx(T_RC, mx(T_AA, T_OE)));
  localparam int EXP_WR = cyc_of(mx(mx(T_WC, T_WP), mx(T_CW, T_DS)));

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wd = '0;
  logic ready_o, rvalid_o, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata_o, dq_o, dq_i;
  logic [10:0] maddr;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_access_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_ce_n_o(ce_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [2048];
  logic rd_ok = 1'b0;
  int aa_cnt = 0, oe_cnt = 0, ce_cnt = 0, we_cnt = 0, ds_cnt = 0, tail_k = 0;
  bit in_rd = 0, in_wr = 0, prev_ce_lo = 0;
  logic [10:0] last_addr = '0, wr_addr = '0;
  logic [7:0]  last_wd = '0;
  logic rvalid_prev = 1'b0;

  wire rd_mode = !ce_n && we_n && !oe_n;
  assign dq_i = rd_mode ? (rd_ok ? mem[maddr] : ~mem[maddr]) : (dq_oe ? dq_o : 8'h00);

  initial for (int i = 0; i < 2048; i++) mem[i] = 8'h00;

  always @(negedge clk) if (rst_ni) begin
    if (!we_n && !oe_n) chk(0, "R5", "oe_n and we_n both low", 0, 1);
    if (dq_oe && !oe_n) chk(0, "R6", "drive with oe_n low", 0, 1);
    if (ready_o && (!ce_n || !we_n || !oe_n || dq_oe))
      chk(0, "R2", "not standby while ready", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    // write tracking
    if (!ce_n && !we_n) begin
      if (!dq_oe) chk(0, "R3", "bus not driven during write", 0, 1);
      if (!in_wr) ds_cnt = 1;
      else if (dq_o != last_wd) ds_cnt = 1;
      else ds_cnt++;
      last_wd = dq_o;
      wr_addr = maddr;
      we_cnt++;
      in_wr = 1;
    end else if (in_wr) begin
      chk((we_cnt * CLK >= T_WP) && ((ce_cnt + 1) * CLK >= T_CW) && (ds_cnt * CLK >= T_DS),
          "R3", "write timing we/ce/ds cycles", we_cnt, EXP_WR);
      chk(we_cnt == EXP_WR, "R7", "write pulse cycles", we_cnt, EXP_WR);
      mem[wr_addr] = last_wd;
      in_wr = 0;
      we_cnt = 0;
    end
    // address, enable counters
    if (ce_n) aa_cnt = 0;
    else if (maddr != last_addr) begin
      if (prev_ce_lo) chk(0, "R8", "address moved while selected", maddr, last_addr);
      aa_cnt = 1;
    end else aa_cnt++;
    last_addr  = maddr;
    prev_ce_lo = !ce_n;
    ce_cnt = ce_n ? 0 : ce_cnt + 1;
    oe_cnt = (ce_n || oe_n) ? 0 : oe_cnt + 1;
    rd_ok  = (aa_cnt * CLK >= T_AA) && (oe_cnt * CLK >= T_OE);
    // memory keeps driving after a read ends
    if (rd_mode) begin in_rd = 1; tail_k = 0; end
    else if (in_rd) begin
      tail_k++;
      if (tail_k * CLK - CLK / 2 >= T_HZ) in_rd = 0;
    end
    if (dq_oe && (rd_mode || in_rd)) chk(0, "R6", "bus contention", tail_k, 0);
  end

  // ---------------- scoreboard ----------------
  logic [7:0] shadow [2048];
  logic [7:0] exp_q[$];
  int         acc_q[$];

  initial for (int i = 0; i < 2048; i++) shadow[i] = 8'h00;

  always @(negedge clk) if (rst_ni) begin
    if (rvalid_o && rvalid_prev) chk(0, "R4", "rvalid longer than one cycle", 2, 1);
    if (rvalid_o) begin
      if (exp_q.size() == 0) chk(0, "R4", "unexpected rvalid", 1, 0);
      else begin
        logic [7:0] e;
        int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        chk(rdata_o == e, "R4", "read data", rdata_o, e);
        chk(cyc == a + EXP_RD, "R7", "read latency", cyc - a, EXP_RD);
      end
    end
    rvalid_prev = rvalid_o;
  end

  task automatic issue(input logic w, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; we = w; addr = a; wd = d;
    if (w) shadow[a] = d;
    else begin
      exp_q.push_back(shadow[a]);
      acc_q.push_back(cyc + 1);
    end
    @(negedge clk);
    req = 1'b0;
    chk(!ready_o, "R9", "ready after accept", ready_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R4", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(ready_o == 1'b1, "R1", "ready in reset", ready_o, 1);
    chk(ce_n && we_n && oe_n, "R1", "strobes in reset", {ce_n, we_n, oe_n}, 3'b111);
    chk(!dq_oe, "R1", "bus enable in reset", dq_oe, 0);
    chk(!rvalid_o, "R1", "rvalid in reset", rvalid_o, 0);
    rst_ni = 1'b1;

    issue(1, 11'd0, 8'hA5);
    issue(1, 11'd2047, 8'h3C);
    issue(0, 11'd0, 8'h00);
    issue(1, 11'd5, 8'h5A);     // write right behind a read: R6 turnaround
    issue(0, 11'd2047, 8'h00);
    issue(0, 11'd5, 8'h00);     // read after read
    issue(0, 11'd9, 8'h00);     // never written: reads 0
    issue(1, 11'd100, 8'h11);
    issue(1, 11'd100, 8'hEE);   // overwrite
    issue(0, 11'd100, 8'h00);
    for (int i = 0; i < 24; i++) begin
      logic [10:0] ra;
      logic [7:0]  rd;
      ra = 11'($urandom % 2048);
      rd = 8'($urandom);
      issue(1, ra, rd);
      issue(0, ra, 8'h00);
      if (i % 3 == 0) issue(1, 11'(ra ^ 11'h2AA), ~rd);
    end
    repeat (20) @(negedge clk);
    chk(ready_o && ce_n && we_n && oe_n && !dq_oe, "R2", "idle standby",
        {ready_o, ce_n, we_n, oe_n, dq_oe}, 5'b11110);
    chk(exp_q.size() == 0, "R4", "all reads returned", exp_q.size(), 0);
    summary();
  end

endmodule